// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Bridge

This block connects the external-memory bus of a small microcontroller to register logic that runs on a faster, unrelated clock. The microcontroller puts the low address byte and the data byte on one shared 8-bit port, and the high address byte on a separate 8-bit port. An address-latch strobe marks the address phase. Active-low read and write strobes mark the data phase. The microcontroller bus runs at about 3.7 MHz. The block runs on a 33 MHz master clock.

The bridge brings the three strobes into the fast domain through synchronizer stages. It delays both bus bytes by the same number of stages, so that bus values and strobes stay aligned. It latches the full 16-bit address while the synchronized address strobe is high, and holds it after the strobe falls. It gives the register logic one-cycle write and read request pulses, together with the address and the write data. For reads it drives the returned byte back towards the shared bus. The output enable comes straight from the raw read strobe, so the port is released as soon as the read strobe rises. The pad buffer is outside the block: the shared port appears as a separate input, output and enable.

Top module: `mux_bus_bridge`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `addr_o`, `wr_data_o`, `ad_o`, `wr_stb_o` and `rd_stb_o` to zero after that edge, and `ad_oe` is 0.
- R2: After an address phase (`ale_i` high), `addr_o` equals {`ah_i`, `ad_i`}, using the values present while `ale_i` was high. Bits 15:8 come from the high port and bits 7:0 from the shared port.
- R3: Once `ale_i` has fallen, `addr_o` keeps the latched value even though `ad_i` changes to data or to other values.
- R4: Each write strobe (`wr_n_i` low, then high) produces exactly one `wr_stb_o` pulse, one cycle long, and only after `wr_n_i` has risen again.
- R5: When `wr_stb_o` is high, `wr_data_o` holds the byte that was on `ad_i` while `wr_n_i` was low, and `addr_o` holds that access's address.
- R6: Each read strobe produces exactly one `rd_stb_o` pulse, one cycle long, while `rd_n_i` is still low, with `addr_o` holding that access's address.
- R7: `ad_oe` is 1 exactly when `rd_n_i` is low (outside reset), without waiting for a clock edge.
- R8: During a read, `ad_o` takes the value of `rd_data_i`, and holds it until the end of the strobe.
- R9: An address phase with no read or write strobe produces no request pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 33 MHz master clock |
| rst | input | 1 | Synchronous reset, active high |
| ale_i | input | 1 | Address-latch strobe from the microcontroller, asynchronous |
| rd_n_i | input | 1 | Read strobe, active low, asynchronous |
| wr_n_i | input | 1 | Write strobe, active low, asynchronous |
| ad_i | input | 8 | Shared address-low/data port, input side |
| ah_i | input | 8 | High address byte port |
| rd_data_i | input | 8 | Read data returned by the register logic |
| ad_o | output | 8 | Shared port, output side (read data) |
| ad_oe | output | 1 | Output enable for the shared port |
| addr_o | output | 16 | Latched request address |
| wr_stb_o | output | 1 | One-cycle write request |
| rd_stb_o | output | 1 | One-cycle read request |
| wr_data_o | output | 8 | Write data for the request |

## Verification
The bench sweeps many address and data patterns through full write and read transactions, timed to the slow bus. It checks the following corner cases:

- **Address after the bus turns to data.** The bench changes the shared port right after the address strobe falls. A latch that is not aligned with its delayed strobe would pick up the data byte as the address.
- **Write timing.** A design that fires on the falling write edge would report the pulse while the strobe is still low, or with stale data. A design that counts a level instead of an edge would give more than one pulse per strobe.
- **Reads and the output enable.** The enable is checked right after each change of the read strobe. The bench also checks address-only phases, and a reset in the middle of an address phase, for spurious pulses and for state that is not cleared.

// File: rtl/mbb_pkg.sv
package mbb_pkg;
  localparam int ADDR_LO_W = 8;
  localparam int ADDR_HI_W = 8;
  localparam int ADDR_W    = ADDR_LO_W + ADDR_HI_W;
  localparam int DATA_W    = ADDR_LO_W;
  localparam int SYNC_DEPTH = 2;

  // Strobe bundle order on the synchronizer: {wr_n, rd_n, ale}
  typedef struct packed {
    logic wr_n;
    logic rd_n;
    logic ale;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{wr_n: 1'b1, rd_n: 1'b1, ale: 1'b0};
endpackage

// File: rtl/mbb_sync.sv
module mbb_sync #(
  parameter int          WIDTH   = 1,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= RST_VAL;
        else     stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= RST_VAL;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/mbb_addr_latch.sv
module mbb_addr_latch #(
  parameter int LO_W = 8,
  parameter int HI_W = 8,
  localparam int AW  = LO_W + HI_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ale_s,
  input  logic [LO_W-1:0] lo_d,
  input  logic [HI_W-1:0] hi_d,
  output logic [AW-1:0]   addr_q
);
  // Follow the aligned bus while the address strobe is high; freeze after.
  always_ff @(posedge clk) begin
    if (rst)        addr_q <= '0;
    else if (ale_s) addr_q <= {hi_d, lo_d};
  end

  assert_addr_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    (!ale_s && !$past(ale_s)) |=> $stable(addr_q));
endmodule

// File: rtl/mbb_strobe_ctrl.sv
module mbb_strobe_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_n_s,
  input  logic          rd_n_s,
  input  logic [DW-1:0] bus_d,
  input  logic [DW-1:0] rd_data_i,
  output logic          wr_stb,
  output logic          rd_stb,
  output logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data_q
);
  logic wr_n_prev, rd_n_prev;
  logic wr_rise, rd_fall;

  assign wr_rise = wr_n_s & ~wr_n_prev;
  assign rd_fall = ~rd_n_s & rd_n_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_n_prev <= 1'b1;
      rd_n_prev <= 1'b1;
      wr_stb    <= 1'b0;
      rd_stb    <= 1'b0;
    end else begin
      wr_n_prev <= wr_n_s;
      rd_n_prev <= rd_n_s;
      wr_stb    <= wr_rise;
      rd_stb    <= rd_fall;
    end
  end

  // Write data tracks the aligned bus while the write strobe is low.
  always_ff @(posedge clk) begin
    if (rst)          wr_data <= '0;
    else if (!wr_n_s) wr_data <= bus_d;
  end

  // Read data from the register logic is registered while reading.
  always_ff @(posedge clk) begin
    if (rst)          rd_data_q <= '0;
    else if (!rd_n_s) rd_data_q <= rd_data_i;
  end

  assert_wr_single_R4: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);
  assert_rd_single_R6: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> !rd_stb);
  assert_wdata_settled_R5: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> $stable(wr_data));
endmodule

// File: rtl/mux_bus_bridge.sv
module mux_bus_bridge
  import mbb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ale_i,
  input  logic                 rd_n_i,
  input  logic                 wr_n_i,
  input  logic [ADDR_LO_W-1:0] ad_i,
  input  logic [ADDR_HI_W-1:0] ah_i,
  input  logic [DATA_W-1:0]    rd_data_i,
  output logic [DATA_W-1:0]    ad_o,
  output logic                 ad_oe,
  output logic [ADDR_W-1:0]    addr_o,
  output logic                 wr_stb_o,
  output logic                 rd_stb_o,
  output logic [DATA_W-1:0]    wr_data_o
);
  strobe_t strb_raw, strb_s;
  logic [ADDR_LO_W-1:0] lo_d;
  logic [ADDR_HI_W-1:0] hi_d;

  assign strb_raw = '{wr_n: wr_n_i, rd_n: rd_n_i, ale: ale_i};

  mbb_sync #(.WIDTH(3), .STAGES(SYNC_DEPTH), .RST_VAL(STROBE_IDLE)) u_strb_sync (
    .clk(clk), .rst(rst), .d(strb_raw), .q(strb_s));

  // Bus bytes get the same delay so they line up with the strobes.
  mbb_sync #(.WIDTH(ADDR_LO_W), .STAGES(SYNC_DEPTH), .RST_VAL('0)) u_lo_dly (
    .clk(clk), .rst(rst), .d(ad_i), .q(lo_d));
  mbb_sync #(.WIDTH(ADDR_HI_W), .STAGES(SYNC_DEPTH), .RST_VAL('0)) u_hi_dly (
    .clk(clk), .rst(rst), .d(ah_i), .q(hi_d));

  mbb_addr_latch #(.LO_W(ADDR_LO_W), .HI_W(ADDR_HI_W)) u_addr (
    .clk(clk), .rst(rst), .ale_s(strb_s.ale), .lo_d(lo_d), .hi_d(hi_d),
    .addr_q(addr_o));

  mbb_strobe_ctrl #(.DW(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_n_s(strb_s.wr_n), .rd_n_s(strb_s.rd_n),
    .bus_d(lo_d), .rd_data_i(rd_data_i), .wr_stb(wr_stb_o), .rd_stb(rd_stb_o),
    .wr_data(wr_data_o), .rd_data_q(ad_o));

  // Output enable follows the raw read strobe so the port frees at once.
  assign ad_oe = ~rd_n_i & ~rst;

  assert_rd_inside_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    rd_stb_o |-> ad_oe);
  assert_no_dual_request_R9: assert property (@(posedge clk) disable iff (rst)
    !(wr_stb_o && rd_stb_o));
endmodule

// File: tb/mux_bus_bridge_tb.sv
module mux_bus_bridge_tb;
  localparam int CLK_PERIOD = 30;
  localparam int N_SWEEP    = 48;
  localparam int HALF_UC    = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ale_i = 1'b0, rd_n_i = 1'b1, wr_n_i = 1'b1;
  logic [7:0]  ad_i = '0, ah_i = '0, rd_data_i = '0;
  logic [7:0]  ad_o, wr_data_o;
  logic        ad_oe, wr_stb_o, rd_stb_o;
  logic [15:0] addr_o;

  int errors = 0, checks = 0;
  int wr_cnt = 0, rd_cnt = 0, wr_early = 0, rd_late = 0;
  logic [15:0] wr_addr_seen, rd_addr_seen;
  logic [7:0]  wr_data_seen;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_bus_bridge u_dut (
    .clk(clk), .rst(rst), .ale_i(ale_i), .rd_n_i(rd_n_i), .wr_n_i(wr_n_i),
    .ad_i(ad_i), .ah_i(ah_i), .rd_data_i(rd_data_i), .ad_o(ad_o), .ad_oe(ad_oe),
    .addr_o(addr_o), .wr_stb_o(wr_stb_o), .rd_stb_o(rd_stb_o),
    .wr_data_o(wr_data_o));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Pulse monitor, sampling away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (wr_stb_o) begin
        wr_cnt++;
        wr_addr_seen = addr_o;
        wr_data_seen = wr_data_o;
        if (!wr_n_i) wr_early++;
      end
      if (rd_stb_o) begin
        rd_cnt++;
        rd_addr_seen = addr_o;
        if (rd_n_i) rd_late++;
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic addr_phase(input logic [7:0] hi, input logic [7:0] lo);
    @(negedge clk);
    ah_i = hi; ale_i = 1'b1; ad_i = lo;
    cyc(2*HALF_UC);
    ale_i = 1'b0;
    cyc(2);
  endtask

  task automatic do_write(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] dat);
    int w0, r0;
    w0 = wr_cnt; r0 = rd_cnt;
    addr_phase(hi, lo);
    ad_i = dat;                   // bus turns to data after ALE drops (R3)
    cyc(2);
    wr_n_i = 1'b0;
    cyc(2*HALF_UC);
    check("R3 address held while data on bus", addr_o, {hi, lo});
    check("R4 no write pulse while strobe low", wr_cnt, w0);
    wr_n_i = 1'b1;
    cyc(2);
    ad_i = ~dat;
    cyc(6);
    check("R4 one write pulse per strobe", wr_cnt, w0 + 1);
    check("R5 write data", wr_data_seen, dat);
    check("R5 write address", wr_addr_seen, {hi, lo});
    check("R9 no read pulse on write", rd_cnt, r0);
  endtask

  task automatic do_read(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] dat);
    int w0, r0;
    w0 = wr_cnt; r0 = rd_cnt;
    addr_phase(hi, lo);
    ad_i = 8'h00;
    rd_data_i = dat;
    cyc(2);
    rd_n_i = 1'b0;
    #1 check("R7 enable on read low", ad_oe, 1'b1);
    cyc(2*HALF_UC);
    check("R6 one read pulse inside strobe", rd_cnt, r0 + 1);
    check("R6 read address", rd_addr_seen, {hi, lo});
    check("R8 read data driven", ad_o, dat);
    check("R2 address latched", addr_o, {hi, lo});
    rd_n_i = 1'b1;
    #1 check("R7 enable off on read high", ad_oe, 1'b0);
    cyc(6);
    check("R9 no write pulse on read", wr_cnt, w0);
  endtask

  initial begin
    cyc(3);
    check("R1 addr after reset", addr_o, 16'h0);
    check("R1 wdata after reset", wr_data_o, 8'h0);
    check("R1 rdata after reset", ad_o, 8'h0);
    check("R1 pulses after reset", {wr_stb_o, rd_stb_o}, 2'b00);
    check("R1 enable in reset", ad_oe, 1'b0);
    rst = 1'b0;
    cyc(2);

    for (int i = 0; i < N_SWEEP; i++) begin
      do_write(8'((i * 37) ^ 8'h5A), 8'(i * 91 + 5), 8'(i ^ 8'hA5));
      do_read(8'(255 - i * 13), 8'((i * 29) ^ 8'h3C), 8'(i * 7 + 1));
    end

    // Walking ones on both address bytes
    for (int b = 0; b < 8; b++) begin
      do_write(8'(1 << b), 8'(1 << (7 - b)), 8'(~(1 << b)));
      do_read(8'(~(1 << b)), 8'(1 << b), 8'(1 << b));
    end

    // Address-only phase: latch updates, no requests (R9, R2)
    begin
      int w0, r0;
      w0 = wr_cnt; r0 = rd_cnt;
      addr_phase(8'hC3, 8'h96);
      ad_i = 8'h11;
      cyc(12);
      check("R9 no write pulse without strobe", wr_cnt, w0);
      check("R9 no read pulse without strobe", rd_cnt, r0);
      check("R2 address-only latch", addr_o, 16'hC396);
    end

    // Reset in the middle of an address phase (R1)
    @(negedge clk);
    ah_i = 8'h77; ad_i = 8'h88; ale_i = 1'b1;
    cyc(4);
    rst = 1'b1;
    cyc(2);
    check("R1 addr cleared mid-phase", addr_o, 16'h0);
    check("R1 wdata cleared", wr_data_o, 8'h0);
    check("R1 rdata cleared", ad_o, 8'h0);
    ale_i = 1'b0;
    rst = 1'b0;
    cyc(6);
    check("R1 address stays clear after release", addr_o, 16'h0);
    do_write(8'h12, 8'h34, 8'h56);

    check("R4 no write pulse before strobe rise", wr_early, 0);
    check("R6 no read pulse after strobe rise", rd_late, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule